// File: doc/BRIEF.md
# Per-Master Address Decoder with Boot Remap

This block turns one bus master's transfer address into a slave choice for a crossbar with four masters and five slaves. Each master owns its own copy of the decoder, and a parameter tells the copy which master it serves. The decoder compares the address against five native slave windows and one boot window that sits at the bottom of the map. It aliases the boot window onto either the ROM or the flash, depending on a remap control bit. It then masks the result with a fixed row of master-to-slave wiring, because not every master is connected to every slave.

The output is either a one-hot slave select or a decode-error flag. The error flag is raised for a valid transfer whose address falls outside every window. It is also raised when the address lands in a window whose slave is not wired to this master. The block has no clock and no storage, so the result belongs to the same cycle as the address. Arbitration, data-phase steering and bus responses are handled by the surrounding crossbar.

Top module: `adec_master_decoder`

## Requirements
- R1: While `valid_i` is low, `sel_o` is all zero and `dec_err_o` is low, whatever the address and remap values are.
- R2: A valid address inside a native window whose slave is wired to this master drives exactly that slave's bit of `sel_o` and leaves `dec_err_o` low. Bit positions: 0 SRAM, 1 ROM, 2 flash, 3 external bus, 4 peripheral bridge.
- R3: With `remap_i` low, a valid address inside the boot window targets the ROM (bit 1).
- R4: With `remap_i` high, a valid address inside the boot window targets the flash (bit 2).
- R5: The native ROM and flash windows decode to their own slaves for both values of `remap_i`.
- R6: A valid address that lies in no window gives `sel_o` all zero and raises `dec_err_o`.
- R7: A valid address whose target slave is not wired to this master gives `sel_o` all zero and raises `dec_err_o`. This applies to aliased boot targets as well. Wiring by master: master 0 reaches ROM and flash only; master 1 reaches SRAM, the external bus and the peripheral bridge; master 2 reaches every slave except flash; master 3 reaches every slave except the peripheral bridge.
- R8: `sel_o` never has more than one bit set, and it is never non-zero while `dec_err_o` is high. A valid transfer always gives exactly one of the two outcomes.
- R9: Each instance applies only the wiring row picked by its `MASTER` parameter, and the result follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W | Transfer address from the master |
| valid_i | input | 1 | Address phase of a transfer is present |
| remap_i | input | 1 | Boot alias target: 0 ROM, 1 flash |
| sel_o | output | NUM_SLV (5) | One-hot slave select |
| dec_err_o | output | 1 | Valid transfer hits no window or an unwired slave |

## Verification
The hardest case to reach is the boot window combined with a wiring row that forbids only one of the two alias targets. For example, master 2 must see a clean ROM select with remap low but an error for the very same address with remap high. The bench uses a narrow address width with small windows and gaps. It sweeps every address under both remap values and both valid values, and all four master instances run side by side. As a result, every window edge, every gap and every alias and wiring combination is visited.

// File: rtl/adec_pkg.sv
package adec_pkg;

  localparam int NUM_SLV = 5;

  localparam int SLV_SRAM  = 0;
  localparam int SLV_ROM   = 1;
  localparam int SLV_FLASH = 2;
  localparam int SLV_EXT   = 3;
  localparam int SLV_PERIPH = 4;

  typedef logic [NUM_SLV-1:0] slv_vec_t;

  // wiring row for a master: bit i set when slave i is reachable
  function automatic slv_vec_t perm_row(input int master);
    slv_vec_t row;
    case (master)
      0:       row = 5'b00110;
      1:       row = 5'b11001;
      2:       row = 5'b11011;
      3:       row = 5'b01111;
      default: row = '0;
    endcase
    return row;
  endfunction

endpackage

// File: rtl/adec_region_cmp.sv
module adec_region_cmp #(
  parameter int              ADDR_W = 32,
  parameter longint unsigned BASE   = 0,
  parameter longint unsigned SIZE   = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [63:0] addr_ext;
  logic [63:0] offset;

  always_comb begin
    addr_ext = 64'(addr_i);
    // an address below BASE wraps to a huge offset and misses
    offset   = addr_ext - 64'(BASE);
    hit_o    = (offset < 64'(SIZE));
  end
endmodule

// File: rtl/adec_boot_alias.sv
module adec_boot_alias
  import adec_pkg::*;
(
  input  slv_vec_t native_hit_i,
  input  logic     boot_hit_i,
  input  logic     remap_i,
  output slv_vec_t target_o
);
  always_comb begin
    target_o = native_hit_i;
    if (boot_hit_i) begin
      if (remap_i) target_o[SLV_FLASH] = 1'b1;
      else         target_o[SLV_ROM]   = 1'b1;
    end
  end
endmodule

// File: rtl/adec_perm_mask.sv
module adec_perm_mask
  import adec_pkg::*;
#(
  parameter int MASTER = 0
) (
  input  slv_vec_t target_i,
  input  logic     valid_i,
  output slv_vec_t sel_o,
  output logic     err_o
);
  localparam slv_vec_t ROW = perm_row(MASTER);

  slv_vec_t allowed;

  always_comb begin
    allowed = target_i & ROW;
    sel_o   = valid_i ? allowed : '0;
    err_o   = valid_i && (allowed == '0);
  end
endmodule

// File: rtl/adec_master_decoder.sv
module adec_master_decoder
  import adec_pkg::*;
#(
  parameter int              MASTER      = 0,
  parameter int              ADDR_W      = 32,
  parameter longint unsigned BOOT_BASE   = 64'h0000_0000,
  parameter longint unsigned BOOT_SIZE   = 64'h0040_0000,
  parameter longint unsigned SRAM_BASE   = 64'h2000_0000,
  parameter longint unsigned SRAM_SIZE   = 64'h1000_0000,
  parameter longint unsigned ROM_BASE    = 64'h0080_0000,
  parameter longint unsigned ROM_SIZE    = 64'h0040_0000,
  parameter longint unsigned FLASH_BASE  = 64'h0040_0000,
  parameter longint unsigned FLASH_SIZE  = 64'h0040_0000,
  parameter longint unsigned EXT_BASE    = 64'h6000_0000,
  parameter longint unsigned EXT_SIZE    = 64'h2000_0000,
  parameter longint unsigned PERIPH_BASE = 64'h4000_0000,
  parameter longint unsigned PERIPH_SIZE = 64'h2000_0000
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               valid_i,
  input  logic               remap_i,
  output logic [NUM_SLV-1:0] sel_o,
  output logic               dec_err_o
);
  localparam longint unsigned BASES [NUM_SLV] =
    '{SRAM_BASE, ROM_BASE, FLASH_BASE, EXT_BASE, PERIPH_BASE};
  localparam longint unsigned SIZES [NUM_SLV] =
    '{SRAM_SIZE, ROM_SIZE, FLASH_SIZE, EXT_SIZE, PERIPH_SIZE};

  slv_vec_t native_hit;
  slv_vec_t target;
  logic     boot_hit;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_win
    adec_region_cmp #(
      .ADDR_W(ADDR_W),
      .BASE  (BASES[g]),
      .SIZE  (SIZES[g])
    ) u_cmp (
      .addr_i(addr_i),
      .hit_o (native_hit[g])
    );
  end

  adec_region_cmp #(
    .ADDR_W(ADDR_W),
    .BASE  (BOOT_BASE),
    .SIZE  (BOOT_SIZE)
  ) u_boot_cmp (
    .addr_i(addr_i),
    .hit_o (boot_hit)
  );

  adec_boot_alias u_alias (
    .native_hit_i(native_hit),
    .boot_hit_i  (boot_hit),
    .remap_i     (remap_i),
    .target_o    (target)
  );

  adec_perm_mask #(
    .MASTER(MASTER)
  ) u_mask (
    .target_i(target),
    .valid_i (valid_i),
    .sel_o   (sel_o),
    .err_o   (dec_err_o)
  );
endmodule

// File: rtl/adec_master_decoder_chk.sv
module adec_master_decoder_chk
  import adec_pkg::*;
#(
  parameter int              MASTER    = 0,
  parameter int              ADDR_W    = 32,
  parameter longint unsigned BOOT_BASE = 0,
  parameter longint unsigned BOOT_SIZE = 1
) (
  input logic [ADDR_W-1:0]  addr_i,
  input logic               valid_i,
  input logic               remap_i,
  input logic [NUM_SLV-1:0] sel_o,
  input logic               dec_err_o
);
  localparam slv_vec_t ROW = perm_row(MASTER);

  logic in_boot;
  always_comb in_boot = ((64'(addr_i) - 64'(BOOT_BASE)) < 64'(BOOT_SIZE));

  always_comb begin
    assert_idle_quiet_R1: assert (valid_i || (sel_o == '0 && !dec_err_o))
      else $error("idle decoder drives an output");
    assert_sel_onehot_R8: assert ($onehot0(sel_o))
      else $error("more than one slave selected");
    assert_sel_err_excl_R8: assert (!(dec_err_o && sel_o != '0))
      else $error("select and error together");
    assert_valid_outcome_R8: assert (!valid_i || dec_err_o || sel_o != '0)
      else $error("valid transfer with no outcome");
    assert_wired_only_R7: assert ((sel_o & ~ROW) == '0)
      else $error("unwired slave selected");
    assert_boot_rom_R3: assert (!(valid_i && in_boot && !remap_i && sel_o[SLV_FLASH]))
      else $error("boot alias hit flash while remap low");
    assert_boot_flash_R4: assert (!(valid_i && in_boot && remap_i && sel_o[SLV_ROM]))
      else $error("boot alias hit ROM while remap high");
  end
endmodule

bind adec_master_decoder adec_master_decoder_chk #(
  .MASTER   (MASTER),
  .ADDR_W   (ADDR_W),
  .BOOT_BASE(BOOT_BASE),
  .BOOT_SIZE(BOOT_SIZE)
) u_chk (.*);

// File: tb/sim_adec_master_decoder.sv
module sim_adec_master_decoder;

  localparam int AW = 12;
  localparam int NM = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          valid;
  logic          remap;
  logic [4:0]    sel_a [NM];
  logic          err_a [NM];

  int n_cmp;
  int n_bad;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R9: one instance per master index, all fed the same stimulus
  for (genvar m = 0; m < NM; m++) begin : g_m
    adec_master_decoder #(
      .MASTER(m), .ADDR_W(AW),
      .BOOT_BASE(64'h000), .BOOT_SIZE(64'h100),
      .FLASH_BASE(64'h100), .FLASH_SIZE(64'h100),
      .ROM_BASE(64'h200), .ROM_SIZE(64'h100),
      .SRAM_BASE(64'h400), .SRAM_SIZE(64'h200),
      .PERIPH_BASE(64'h800), .PERIPH_SIZE(64'h200),
      .EXT_BASE(64'hC00), .EXT_SIZE(64'h200)
    ) u0 (
      .addr_i(addr), .valid_i(valid), .remap_i(remap),
      .sel_o(sel_a[m]), .dec_err_o(err_a[m])
    );
  end

  function automatic logic [4:0] row_of(input int m);
    case (m)
      0: return 5'b00110;
      1: return 5'b11001;
      2: return 5'b11011;
      default: return 5'b01111;
    endcase
  endfunction

  // returns target slave index, or -1 for no window; kind names the rule
  function automatic int target_of(input int a, input bit r, output string kind);
    if (a < 'h100)                  begin kind = r ? "R4" : "R3"; return r ? 2 : 1; end
    if (a >= 'h100 && a < 'h200)    begin kind = r ? "R5" : "R2"; return 2; end
    if (a >= 'h200 && a < 'h300)    begin kind = r ? "R5" : "R2"; return 1; end
    if (a >= 'h400 && a < 'h600)    begin kind = "R2"; return 0; end
    if (a >= 'h800 && a < 'hA00)    begin kind = "R2"; return 4; end
    if (a >= 'hC00 && a < 'hE00)    begin kind = "R2"; return 3; end
    kind = "R6";
    return -1;
  endfunction

  task automatic compare(input int m, input logic [4:0] es, input logic ee, input string tag);
    n_cmp++;
    if (sel_a[m] !== es || err_a[m] !== ee) begin
      n_bad++;
      $display("FAIL %s master %0d addr %h remap %0d valid %0d: sel %b err %b expected sel %b err %b",
               tag, m, addr, remap, valid, sel_a[m], err_a[m], es, ee);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    addr  = '0;
    valid = 1'b0;
    remap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < NM; m++) compare(m, 5'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;

    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 2; v++) begin
        for (int a = 0; a < (1 << AW); a++) begin
          @(posedge clk);
          addr  = AW'(a);
          remap = r[0];
          valid = v[0];
          @(negedge clk);
          for (int m = 0; m < NM; m++) begin
            string kind;
            int t;
            logic [4:0] es;
            logic ee;
            t = target_of(a, r[0], kind);
            if (v == 0) begin
              es = '0; ee = 1'b0; kind = "R1";
            end else if (t < 0) begin
              es = '0; ee = 1'b1;
            end else if (row_of(m)[t] == 1'b0) begin
              es = '0; ee = 1'b1; kind = "R7";
            end else begin
              es = 5'(1 << t); ee = 1'b0;
            end
            compare(m, es, ee, kind);
            // R8: structural outcome check at the ports
            n_cmp++;
            if ($countones(sel_a[m]) > 1 || (err_a[m] && sel_a[m] != 0)) begin
              n_bad++;
              $display("FAIL R8 master %0d addr %h: sel %b err %b expected at most one outcome",
                       m, addr, sel_a[m], err_a[m]);
            end
          end
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule